// File: doc/BRIEF.md
# Stepper Return-to-Zero Stall Detection Sequencer

This block is the digital half of a stall detector that drives a two-coil stepper motor back to its mechanical end stop. For each commanded step it powers exactly one coil with one polarity and leaves the other coil floating. It then waits out a blanking interval so that the recirculation current in the floating coil can decay. After that it integrates the back-EMF induced in that coil, which arrives as a one-bit sigma-delta stream from an external modulator.

A single down counter times both phases from two reload values. When the integration window closes, the signed accumulator is frozen and compared with a programmable threshold. The block then sets or clears a stall flag and pulses an interrupt. Software reads the accumulator and flag, then commands the next step. Direction and polarity inputs let the pointer be driven toward zero either way.

Top module: `stall_detect`

## Requirements
- R1: After reset the step index is 0, so coil A is driven positive and coil B floats. The accumulator reads 0, and the stall flag and interrupt are low.
- R2: A step command (`step_go` high for one cycle while idle) moves the step index to index+1 mod 4 when `dir_ccw`=0 and to index-1 mod 4 when `dir_ccw`=1. Drive codes are 00 float, 01 positive and 10 negative. With `pol_inv`=0, index 0 gives A=01/B=00, index 1 gives A=00/B=01, index 2 gives A=10/B=00 and index 3 gives A=00/B=10.
- R3: With `pol_inv`=1, codes 01 and 10 are swapped on whichever coil is powered.
- R4: At every cycle exactly one coil carries a non-float code.
- R5: Blanking lasts max(`blank_len`,1) cycles after the step command is taken. During blanking the accumulator reads 0 and modulator samples are ignored.
- R6: Integration then samples `sd_bit` for max(`integ_len`,1) cycles, adding 1 for each sample of 1 and subtracting 1 for each sample of 0.
- R7: The signed 16-bit accumulator saturates at +32767 and -32768 instead of wrapping.
- R8: `irq` is high for exactly one cycle, in the cycle after the last integrated sample. From then on the accumulator holds its value until the next step command.
- R9: At completion, `stall` is set when the final accumulator is below `threshold` (signed) and cleared otherwise, including when the two are equal. It holds until the next completion.
- R10: `step_go` is ignored while a measurement is in progress, including in the last integration cycle. The step index and the completion timing are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_go | input | 1 | Command one step and measurement |
| dir_ccw | input | 1 | 0: step index forward, 1: backward |
| pol_inv | input | 1 | Swap drive polarity |
| blank_len | input | 16 | Blanking reload value |
| integ_len | input | 16 | Integration reload value |
| threshold | input | 16 | Signed stall threshold |
| sd_bit | input | 1 | Sigma-delta back-EMF bitstream |
| coil_a | output | 2 | Coil A drive code |
| coil_b | output | 2 | Coil B drive code |
| acc_out | output | 16 | Signed accumulator readback |
| stall | output | 1 | Stall decision |
| irq | output | 1 | Measurement complete pulse |

## Verification
The end of an integration window and a new step command can land in the same cycle. The bench provokes this by holding `step_go` high in the final integration cycle, and also during blanking. It judges the outcome at the ports: the completion pulse must still come on time with the correct accumulator and flag, and the coil codes must show that the step index did not move. Saturation is approached from both sides with windows longer than the accumulator range.

// File: rtl/stall_pkg.sv
package stall_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BLANK = 2'd1,
        PH_INTEG = 2'd2
    } phase_e;

    localparam logic [1:0] DRV_FLOAT = 2'b00;
    localparam logic [1:0] DRV_POS   = 2'b01;
    localparam logic [1:0] DRV_NEG   = 2'b10;
endpackage

// File: rtl/coil_decode.sv
module coil_decode
    import stall_pkg::*;
(
    input  logic [1:0] step_idx,
    input  logic       pol_inv,
    output logic [1:0] drv_a,
    output logic [1:0] drv_b
);
    logic [1:0] drv [2];

    // Even index powers coil A, odd index powers coil B; upper bit picks sign.
    for (genvar g = 0; g < 2; g++) begin : g_coil
        always_comb begin
            if (step_idx[0] == 1'(g))
                drv[g] = (step_idx[1] ^ pol_inv) ? DRV_NEG : DRV_POS;
            else
                drv[g] = DRV_FLOAT;
        end
    end

    assign drv_a = drv[0];
    assign drv_b = drv[1];
endmodule

// File: rtl/sat_step.sv
module sat_step #(
    parameter int ACC_W = 16
) (
    input  logic signed [ACC_W-1:0] acc_in,
    input  logic                    up,
    output logic signed [ACC_W-1:0] acc_nxt
);
    localparam logic signed [ACC_W:0] MAX_V = (ACC_W+1)'((1 << (ACC_W-1)) - 1);
    localparam logic signed [ACC_W:0] MIN_V = -(ACC_W+1)'(1 << (ACC_W-1));

    logic signed [ACC_W:0] wide;

    always_comb begin
        wide = up ? ({acc_in[ACC_W-1], acc_in} + (ACC_W+1)'(1))
                  : ({acc_in[ACC_W-1], acc_in} - (ACC_W+1)'(1));
        if (wide > MAX_V)
            acc_nxt = MAX_V[ACC_W-1:0];
        else if (wide < MIN_V)
            acc_nxt = MIN_V[ACC_W-1:0];
        else
            acc_nxt = wide[ACC_W-1:0];
    end
endmodule

// File: rtl/stall_detect.sv
module stall_detect
    import stall_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_go,
    input  logic                    dir_ccw,
    input  logic                    pol_inv,
    input  logic [CNT_W-1:0]        blank_len,
    input  logic [CNT_W-1:0]        integ_len,
    input  logic signed [ACC_W-1:0] threshold,
    input  logic                    sd_bit,
    output logic [1:0]              coil_a,
    output logic [1:0]              coil_b,
    output logic signed [ACC_W-1:0] acc_out,
    output logic                    stall,
    output logic                    irq
);
    localparam int IDX_W = 2;

    typedef struct packed {
        phase_e                  phase;
        logic [IDX_W-1:0]        idx;
        logic [CNT_W-1:0]        cnt;
        logic signed [ACC_W-1:0] acc;
        logic                    stall;
        logic                    irq;
    } state_t;

    state_t q, d;
    logic signed [ACC_W-1:0] acc_step;
    logic                    cnt_last;

    sat_step #(.ACC_W(ACC_W)) u_sat (
        .acc_in (q.acc),
        .up     (sd_bit),
        .acc_nxt(acc_step)
    );

    coil_decode u_coil (
        .step_idx(q.idx),
        .pol_inv (pol_inv),
        .drv_a   (coil_a),
        .drv_b   (coil_b)
    );

    // A reload of 0 behaves like 1: every phase lasts at least one cycle.
    assign cnt_last = (q.cnt[CNT_W-1:1] == '0);

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (step_go) begin
                    d.phase = PH_BLANK;
                    d.idx   = dir_ccw ? q.idx - 1'b1 : q.idx + 1'b1;
                    d.cnt   = blank_len;
                    d.acc   = '0;
                end
            end
            PH_BLANK: begin
                if (cnt_last) begin
                    d.phase = PH_INTEG;
                    d.cnt   = integ_len;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_INTEG: begin
                d.acc = acc_step;
                if (cnt_last) begin
                    d.phase = PH_IDLE;
                    d.stall = (acc_step < threshold);
                    d.irq   = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= PH_IDLE;
            q.idx   <= '0;
            q.cnt   <= '0;
            q.acc   <= '0;
            q.stall <= 1'b0;
            q.irq   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign acc_out = q.acc;
    assign stall   = q.stall;
    assign irq     = q.irq;
endmodule

// File: rtl/stall_detect_chk.sv
module stall_detect_chk
    import stall_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input phase_e                  phase,
    input logic signed [ACC_W-1:0] acc,
    input logic                    irq,
    input logic                    stall,
    input logic [1:0]              coil_a,
    input logic [1:0]              coil_b
);
    a_r4_single_coil: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({coil_a != DRV_FLOAT, coil_b != DRV_FLOAT}) == 1);

    a_r5_blank_acc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BLANK) |-> (acc == '0));

    a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INTEG && $past(phase) == PH_INTEG) |->
        (acc == $past(acc) || 32'(acc) == 32'($past(acc)) + 1
                           || 32'(acc) == 32'($past(acc)) - 1));

    a_r8_irq_after_integ: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(phase) == PH_INTEG && phase == PH_IDLE));

    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r8_acc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && $past(phase) == PH_IDLE) |-> $stable(acc));

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(stall));
endmodule

bind stall_detect stall_detect_chk #(.ACC_W(ACC_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (q.phase),
    .acc   (acc_out),
    .irq   (irq),
    .stall (stall),
    .coil_a(coil_a),
    .coil_b(coil_b)
);

// File: tb/stall_detect_bench.sv
module stall_detect_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               step_go = 1'b0;
    logic               dir_ccw = 1'b0;
    logic               pol_inv = 1'b0;
    logic [15:0]        blank_len = '0;
    logic [15:0]        integ_len = '0;
    logic signed [15:0] threshold = '0;
    logic               sd_bit = 1'b0;
    logic [1:0]         coil_a, coil_b;
    logic signed [15:0] acc_out;
    logic               stall, irq;

    int checks = 0;
    int fails  = 0;
    int exp_idx = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stall_detect u_stall_detect (
        .clk(clk), .rst_n(rst_n), .step_go(step_go), .dir_ccw(dir_ccw),
        .pol_inv(pol_inv), .blank_len(blank_len), .integ_len(integ_len),
        .threshold(threshold), .sd_bit(sd_bit), .coil_a(coil_a),
        .coil_b(coil_b), .acc_out(acc_out), .stall(stall), .irq(irq)
    );

    function automatic logic [1:0] exp_coil(int idx, bit pinv, int which);
        if ((idx % 2) != which) return 2'b00;
        return ((idx >= 2) ^ pinv) ? 2'b10 : 2'b01;
    endfunction

    function automatic int sat_add(int a, bit up);
        if (up) return (a < 32767) ? a + 1 : a;
        return (a > -32768) ? a - 1 : a;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // mode 0: random samples, 1: all ones, 2: all zeros during integration
    task automatic run_step(bit ccw, bit pinv, int bl, int il, int thr,
                            int mode, bit inject, output int acc_final);
        int be = (bl < 1) ? 1 : bl;
        int ie = (il < 1) ? 1 : il;
        int ea = 0;
        bit bad = 1'b0;
        bit sb;
        int held;
        @(negedge clk);
        dir_ccw = ccw; pol_inv = pinv; blank_len = 16'(bl);
        integ_len = 16'(il); threshold = 16'(thr); step_go = 1'b1;
        exp_idx = ccw ? (exp_idx + 3) % 4 : (exp_idx + 1) % 4;
        @(posedge clk);
        for (int k = 1; k <= be + ie; k++) begin
            @(negedge clk);
            step_go = inject && (k == 2 || k == be + ie);
            if (k == 1) begin
                check(pinv ? "R3 coil_a" : "R2 coil_a", coil_a, exp_coil(exp_idx, pinv, 0));
                check(pinv ? "R3 coil_b" : "R2 coil_b", coil_b, exp_coil(exp_idx, pinv, 1));
                check("R4 one coil", int'(coil_a != 0) + int'(coil_b != 0), 1);
            end
            if (irq !== 1'b0) bad = 1'b1;
            if (k <= be && acc_out !== 16'sd0) bad = 1'b1;
            if (k <= be) sb = 1'($urandom);
            else begin
                case (mode)
                    1: sb = 1'b1;
                    2: sb = 1'b0;
                    default: sb = 1'($urandom);
                endcase
                ea = sat_add(ea, sb);
            end
            sd_bit = sb;
            @(posedge clk);
        end
        @(negedge clk);
        step_go = 1'b0;
        check("R5 blanking quiet", int'(bad), 0);
        check("R8 irq at end", int'(irq), 1);
        check("R6 acc value", int'(acc_out), ea);
        check("R9 stall flag", int'(stall), int'(ea < thr));
        check("R10 index kept", int'({coil_a, coil_b}),
              int'({exp_coil(exp_idx, pinv, 0), exp_coil(exp_idx, pinv, 1)}));
        held = int'(acc_out);
        sd_bit = ~sd_bit;
        @(negedge clk);
        check("R8 irq one cycle", int'(irq), 0);
        check("R8 acc frozen", int'(acc_out), held);
        acc_final = ea;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 coil_a", coil_a, 2'b01);
        check("R1 coil_b", coil_b, 2'b00);
        check("R1 acc", int'(acc_out), 0);
        check("R1 stall", int'(stall), 0);
        check("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: equal to threshold means moving, one above means stall
        run_step(1'b0, 1'b0, 3, 5, 5, 1, 1'b0, r);
        check("R9 equal not stalled", int'(stall), 0);
        run_step(1'b0, 1'b0, 3, 5, 6, 1, 1'b0, r);
        check("R9 below stalled", int'(stall), 1);
        // R5/R6 zero reloads behave as one cycle each
        run_step(1'b0, 1'b0, 0, 0, 0, 2, 1'b0, r);
        check("R6 single sample", r, -1);
        // R10: commands during blanking and in the final integration cycle
        run_step(1'b1, 1'b1, 4, 6, 0, 0, 1'b1, r);
        run_step(1'b1, 1'b0, 1, 2, 0, 0, 1'b1, r);
        // R7 saturation both ways
        run_step(1'b0, 1'b0, 2, 40000, 0, 1, 1'b0, r);
        check("R7 upper clamp", int'(acc_out), 32767);
        run_step(1'b1, 1'b1, 2, 40000, 0, 2, 1'b0, r);
        check("R7 lower clamp", int'(acc_out), -32768);

        for (int n = 0; n < 24; n++) begin
            run_step(1'($urandom), 1'($urandom), int'($urandom % 21),
                     int'($urandom % 61), int'($urandom % 61) - 30,
                     int'($urandom % 3), 1'($urandom), r);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule